// File: doc/BRIEF.md
# ADC Conversion Result Register Bank

This block keeps the finished conversion results of an eight-channel analog-to-digital converter where a processor can read them. Each completed conversion arrives as a one-cycle strobe that carries a channel number and a 10-bit code. The block stores the code in that channel's data register and marks the channel as having fresh data. In burst operation it also notes when an unread result has been overwritten. Every register read returns its data one cycle after the read strobe.

The fresh-data and lost-data flags of a channel clear when software reads that channel's data register. Both flag sets are also copied into one status word, which software can read without clearing anything. An interrupt line is raised while any channel has fresh data and its bit in the interrupt-enable mask is set. A small trim register holds a 4-bit offset correction. It starts from a build-time value and can be rewritten.

Top module: `adc_result_bank`

## Requirements
- R1: Channel n (0 to 7) has a data register at byte offset 0x10 + 4n. Its layout is: code in bits 15:6, lost-data flag in bit 30, fresh-data flag in bit 31, and zero in bits 29:16 and 5:0.
- R2: A completion strobe stores the code in the indexed channel and sets that channel's fresh-data flag from the next cycle on. No other channel changes.
- R3: A read of a channel's data register returns the register's contents on `bus_rdata` in the cycle after the read strobe. It clears that channel's fresh-data and lost-data flags but keeps the stored code.
- R4: The lost-data flag is set when `burst_en` is high and a new code arrives while the channel's fresh-data flag is still set.
- R5: When `burst_en` is low, a new code replaces an unread one and the lost-data flag does not change.
- R6: The status register at offset 0x30 holds the fresh-data flags in bits 7:0 and the lost-data flags in bits 15:8, one bit per channel. Bit 16 is the interrupt flag and bits 31:17 are zero. Reading it clears no flag.
- R7: `irq` is high exactly when at least one channel has its fresh-data flag set and its `int_en` bit set.
- R8: If a completion on a channel coincides with a read of that channel's data register, the read returns the old contents. Afterwards the fresh-data flag stays set with the new code and the lost-data flag is clear.
- R9: The trim register at offset 0x34 holds a 4-bit field in bits 7:4 and reads zero in its other bits. The field resets to `TRIM_INIT` and a bus write loads it from `bus_wdata[7:4]`.
- R10: Reads of any other offset, including unaligned ones, return zero. Writes to data and status registers change nothing.
- R11: After reset, all codes and flags are zero, `irq` is low and `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle conversion-complete strobe |
| conv_chan | input | 3 | Channel of the finished conversion |
| conv_result | input | 10 | Converted code |
| burst_en | input | 1 | Burst operation active |
| int_en | input | 8 | Per-channel interrupt enable |
| bus_addr | input | 8 | Byte offset of register access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
A completion strobe applied before a clock edge is visible in the flags, the status word and `irq` right after that edge. Read data is registered, so a read strobe taken at an edge places its result on `bus_rdata` after that same edge. The flags it clears take effect at that edge as well. The bench drives every stimulus on the falling edge and samples on the next falling edge. A scoreboard queue pairs each read with the value its driver predicted. The monitor pops an entry only on the falling edge after a clock edge where the bench itself saw a read strobe.

// File: rtl/adc_bank_pkg.sv
package adc_bank_pkg;

    localparam int BUS_W       = 32;
    localparam int DATA_BASE   = 'h10;
    localparam int STAT_OFF    = 'h30;
    localparam int TRIM_OFF    = 'h34;
    localparam int FRESH_BIT   = 31;
    localparam int LOST_BIT    = 30;
    localparam int CODE_LSB    = 6;
    localparam int TRIM_LSB    = 4;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_DATA = 2'd1,
        REG_STAT = 2'd2,
        REG_TRIM = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/adc_chan_slot.sv
module adc_chan_slot #(
    parameter int IDX   = 0,
    parameter int CH_W  = 3,
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_done,
    input  logic [CH_W-1:0]  conv_chan,
    input  logic [RES_W-1:0] conv_result,
    input  logic             burst_en,
    input  logic             rd_clr,
    output logic [RES_W-1:0] code,
    output logic             fresh,
    output logic             lost
);

    typedef struct packed {
        logic [RES_W-1:0] code;
        logic             fresh;
        logic             lost;
    } slot_t;

    slot_t st_d, st_q;
    logic  hit;

    assign hit = conv_done && (conv_chan == CH_W'(IDX));

    always_comb begin
        st_d = st_q;
        if (rd_clr) begin
            st_d.fresh = 1'b0;
            st_d.lost  = 1'b0;
        end
        if (hit) begin
            if (burst_en && st_q.fresh && !rd_clr) begin
                st_d.lost = 1'b1;
            end
            st_d.fresh = 1'b1;
            st_d.code  = conv_result;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code  = st_q.code;
    assign fresh = st_q.fresh;
    assign lost  = st_q.lost;

endmodule

// File: rtl/adc_reg_decode.sv
module adc_reg_decode
    import adc_bank_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output reg_sel_e          sel,
    output logic [$clog2(NUM_CH)-1:0] chan_idx,
    output logic [NUM_CH-1:0] rd_clr,
    output logic              trim_wr
);

    localparam int CH_W     = $clog2(NUM_CH);
    localparam int DATA_END = DATA_BASE + 4 * NUM_CH;

    logic             aligned;
    logic [ADDR_W-1:0] rel;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign rel     = bus_addr - ADDR_W'(DATA_BASE);

    always_comb begin
        sel = REG_NONE;
        if (aligned) begin
            if (bus_addr >= ADDR_W'(DATA_BASE) && bus_addr < ADDR_W'(DATA_END)) begin
                sel = REG_DATA;
            end else if (bus_addr == ADDR_W'(STAT_OFF)) begin
                sel = REG_STAT;
            end else if (bus_addr == ADDR_W'(TRIM_OFF)) begin
                sel = REG_TRIM;
            end
        end
    end

    assign chan_idx = CH_W'(rel >> 2);

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_clr
            assign rd_clr[g] = bus_rd && (sel == REG_DATA) && (chan_idx == CH_W'(g));
        end
    endgenerate

    assign trim_wr = bus_wr && (sel == REG_TRIM);

endmodule

// File: rtl/adc_trim_reg.sv
module adc_trim_reg #(
    parameter int          TRIM_W    = 4,
    parameter logic [3:0]  TRIM_INIT = 4'h8,
    parameter int          LSB       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [31:0]       wdata,
    output logic [TRIM_W-1:0] trim
);

    typedef struct packed {
        logic [TRIM_W-1:0] val;
    } trim_t;

    trim_t tr_d, tr_q;

    always_comb begin
        tr_d = tr_q;
        if (wr) begin
            tr_d.val = wdata[LSB +: TRIM_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tr_q.val <= TRIM_W'(TRIM_INIT);
        end else begin
            tr_q <= tr_d;
        end
    end

    assign trim = tr_q.val;

endmodule

// File: rtl/adc_read_mux.sv
module adc_read_mux
    import adc_bank_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 10,
    parameter int TRIM_W = 4
) (
    input  reg_sel_e                    sel,
    input  logic [$clog2(NUM_CH)-1:0]   chan_idx,
    input  logic [NUM_CH*RES_W-1:0]     codes,
    input  logic [NUM_CH-1:0]           fresh_vec,
    input  logic [NUM_CH-1:0]           lost_vec,
    input  logic                        int_flag,
    input  logic [TRIM_W-1:0]           trim,
    output logic [BUS_W-1:0]            word
);

    always_comb begin
        word = '0;
        unique case (sel)
            REG_DATA: begin
                word[CODE_LSB +: RES_W] = codes[chan_idx*RES_W +: RES_W];
                word[LOST_BIT]          = lost_vec[chan_idx];
                word[FRESH_BIT]         = fresh_vec[chan_idx];
            end
            REG_STAT: begin
                word[0 +: NUM_CH]      = fresh_vec;
                word[NUM_CH +: NUM_CH] = lost_vec;
                word[2*NUM_CH]         = int_flag;
            end
            REG_TRIM: begin
                word[TRIM_LSB +: TRIM_W] = trim;
            end
            default: word = '0;
        endcase
    end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_bank_pkg::*;
#(
    parameter int         NUM_CH    = 8,
    parameter int         RES_W     = 10,
    parameter int         ADDR_W    = 8,
    parameter int         TRIM_W    = 4,
    parameter logic [3:0] TRIM_INIT = 4'h8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      conv_done,
    input  logic [$clog2(NUM_CH)-1:0] conv_chan,
    input  logic [RES_W-1:0]          conv_result,
    input  logic                      burst_en,
    input  logic [NUM_CH-1:0]         int_en,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_rd,
    input  logic                      bus_wr,
    input  logic [BUS_W-1:0]          bus_wdata,
    output logic [BUS_W-1:0]          bus_rdata,
    output logic                      irq
);

    localparam int CH_W = $clog2(NUM_CH);

    typedef struct packed {
        logic [BUS_W-1:0] rdata;
    } top_t;

    top_t top_d, top_q;

    reg_sel_e              sel;
    logic [CH_W-1:0]       chan_idx;
    logic [NUM_CH-1:0]     rd_clr;
    logic                  trim_wr;
    logic [NUM_CH*RES_W-1:0] codes;
    logic [NUM_CH-1:0]     fresh_vec;
    logic [NUM_CH-1:0]     lost_vec;
    logic [TRIM_W-1:0]     trim;
    logic                  int_flag;
    logic [BUS_W-1:0]      mux_word;

    adc_reg_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .sel      (sel),
        .chan_idx (chan_idx),
        .rd_clr   (rd_clr),
        .trim_wr  (trim_wr)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
            adc_chan_slot #(
                .IDX   (g),
                .CH_W  (CH_W),
                .RES_W (RES_W)
            ) u_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .conv_done   (conv_done),
                .conv_chan   (conv_chan),
                .conv_result (conv_result),
                .burst_en    (burst_en),
                .rd_clr      (rd_clr[g]),
                .code        (codes[g*RES_W +: RES_W]),
                .fresh       (fresh_vec[g]),
                .lost        (lost_vec[g])
            );
        end
    endgenerate

    adc_trim_reg #(
        .TRIM_W    (TRIM_W),
        .TRIM_INIT (TRIM_INIT),
        .LSB       (TRIM_LSB)
    ) u_trim (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (trim_wr),
        .wdata (bus_wdata),
        .trim  (trim)
    );

    assign int_flag = |(fresh_vec & int_en);

    adc_read_mux #(
        .NUM_CH (NUM_CH),
        .RES_W  (RES_W),
        .TRIM_W (TRIM_W)
    ) u_mux (
        .sel       (sel),
        .chan_idx  (chan_idx),
        .codes     (codes),
        .fresh_vec (fresh_vec),
        .lost_vec  (lost_vec),
        .int_flag  (int_flag),
        .trim      (trim),
        .word      (mux_word)
    );

    always_comb begin
        top_d = top_q;
        if (bus_rd) begin
            top_d.rdata = mux_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign bus_rdata = top_q.rdata;
    assign irq       = int_flag;

endmodule

// File: rtl/adc_result_bank_chk.sv
module adc_result_bank_chk
    import adc_bank_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      conv_done,
    input logic [$clog2(NUM_CH)-1:0] conv_chan,
    input logic                      burst_en,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      bus_rd,
    input logic [BUS_W-1:0]          bus_rdata,
    input logic                      irq,
    input logic [NUM_CH-1:0]         fresh_vec,
    input logic [NUM_CH-1:0]         lost_vec
);

    localparam int CH_W     = $clog2(NUM_CH);
    localparam int DATA_END = DATA_BASE + 4 * NUM_CH;

    logic in_data, in_any;
    assign in_data = (bus_addr[1:0] == 2'b00) &&
                     bus_addr >= ADDR_W'(DATA_BASE) && bus_addr < ADDR_W'(DATA_END);
    assign in_any  = in_data || bus_addr == ADDR_W'(STAT_OFF) || bus_addr == ADDR_W'(TRIM_OFF);

    p_fresh_after_conv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> fresh_vec[$past(conv_chan)]);

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && in_data) |=> (bus_rdata[29:16] == 14'd0 && bus_rdata[5:0] == 6'd0));

    p_status_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(STAT_OFF) && !conv_done)
        |=> (fresh_vec == $past(fresh_vec) && lost_vec == $past(lost_vec)));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_any) |=> (bus_rdata == '0));

    p_irq_needs_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (fresh_vec != '0));

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_rd && bus_addr == ADDR_W'(DATA_BASE + 4 * g) &&
                 !(conv_done && conv_chan == CH_W'(g)))
                |=> (!fresh_vec[g] && !lost_vec[g]));

            p_lost_needs_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (lost_vec[g] && !$past(lost_vec[g])) |-> $past(burst_en && fresh_vec[g]));
        end
    endgenerate

endmodule

bind adc_result_bank adc_result_bank_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_done (conv_done),
    .conv_chan (conv_chan),
    .burst_en  (burst_en),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .fresh_vec (fresh_vec),
    .lost_vec  (lost_vec)
);

// File: tb/adc_result_bank_bench.sv
`timescale 1ns/1ps
module adc_result_bank_bench;

    localparam logic [3:0] TINIT = 4'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [2:0]  conv_chan = '0;
    logic [9:0]  conv_result = '0;
    logic        burst_en = 1'b0;
    logic [7:0]  int_en = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [9:0] m_code [8];
    logic [7:0] m_fresh = '0;
    logic [7:0] m_lost  = '0;
    logic [3:0] m_trim  = TINIT;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;

    always #2 clk = ~clk;

    adc_result_bank u_adc_result_bank (
        .clk, .rst_n, .conv_done, .conv_chan, .conv_result, .burst_en, .int_en,
        .bus_addr, .bus_rd, .bus_wr, .bus_wdata, .bus_rdata, .irq
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_word(logic [7:0] a);
        logic [31:0] w = '0;
        if (a[1:0] == 2'b00 && a >= 8'h10 && a < 8'h30) begin
            int c = (a - 8'h10) >> 2;
            w[15:6] = m_code[c];
            w[30]   = m_lost[c];
            w[31]   = m_fresh[c];
        end else if (a == 8'h30) begin
            w[7:0]  = m_fresh;
            w[15:8] = m_lost;
            w[16]   = |(m_fresh & int_en);
        end else if (a == 8'h34) begin
            w[7:4] = m_trim;
        end
        return w;
    endfunction

    function automatic void model_conv(int c, logic [9:0] v, bit cleared);
        if (burst_en && m_fresh[c] && !cleared) m_lost[c] = 1'b1;
        m_fresh[c] = 1'b1;
        m_code[c]  = v;
    endfunction

    function automatic void model_read(logic [7:0] a);
        if (a[1:0] == 2'b00 && a >= 8'h10 && a < 8'h30) begin
            int c = (a - 8'h10) >> 2;
            m_fresh[c] = 1'b0;
            m_lost[c]  = 1'b0;
        end
    endfunction

    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("scoreboard", 32'hDEAD, 32'h0);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic conv(int c, logic [9:0] v);
        @(negedge clk);
        conv_done = 1'b1; conv_chan = 3'(c); conv_result = v;
        model_conv(c, v, 1'b0);
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(model_word(a));
        tag_q.push_back(tag);
        model_read(a);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_conv(int c, logic [9:0] v, string tag);
        logic [7:0] a = 8'(8'h10 + 4 * c);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        conv_done = 1'b1; conv_chan = 3'(c); conv_result = v;
        exp_q.push_back(model_word(a));
        tag_q.push_back(tag);
        model_read(a);
        model_conv(c, v, 1'b1);
        @(negedge clk);
        bus_rd = 1'b0; conv_done = 1'b0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        if (a == 8'h34) m_trim = d[7:4];
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m_code[i] = '0;
        repeat (3) @(negedge clk);
        check("R11 rdata reset", bus_rdata, 32'h0);
        check("R11 irq reset", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        rd(8'h30, "R11 status reset");
        for (int i = 0; i < 8; i++) rd(8'(8'h10 + 4 * i), "R11 data reset");
        rd(8'h34, "R9 trim init");

        conv(3, 10'h155);
        check("R7 irq masked", {31'h0, irq}, 32'h0);
        rd(8'h30, "R2 R6 status after conv");
        rd(8'h30, "R6 status read twice");
        int_en = 8'h08;
        @(negedge clk);
        check("R7 irq enabled", {31'h0, irq}, 32'h1);
        rd(8'h30, "R6 int flag");
        rd(8'h1C, "R1 R3 read ch3");
        check("R7 irq after clear", {31'h0, irq}, 32'h0);
        rd(8'h1C, "R3 flags cleared code kept");

        conv(5, 10'h3FF);
        conv(5, 10'h001);
        rd(8'h30, "R5 no lost flag");
        rd(8'h24, "R5 silent overwrite");

        burst_en = 1'b1;
        conv(6, 10'h200);
        conv(6, 10'h0AA);
        rd(8'h30, "R4 status lost bit");
        rd(8'h28, "R4 lost data read");
        rd(8'h28, "R3 lost cleared");
        conv(6, 10'h0BB);
        rd(8'h28, "R4 no lost after read");

        conv(2, 10'h111);
        rd_conv(2, 10'h222, "R8 old contents");
        rd(8'h18, "R8 new code kept");

        int_en = 8'h81;
        conv(7, 10'h3C3);
        check("R7 irq ch7", {31'h0, irq}, 32'h1);
        conv(0, 10'h000);
        rd(8'h2C, "R1 ch7 data");
        check("R7 irq ch0 left", {31'h0, irq}, 32'h1);
        rd(8'h10, "R1 ch0 data");
        check("R7 irq all clear", {31'h0, irq}, 32'h0);

        conv(1, 10'h2F0);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h14, "R10 data write ignored");
        rd(8'h30, "R10 status write ignored");
        rd(8'h00, "R10 unmapped 0x00");
        rd(8'h0C, "R10 unmapped 0x0C");
        rd(8'h38, "R10 unmapped 0x38");
        rd(8'h11, "R10 unaligned");

        wr(8'h34, 32'hFFFF_FFA5);
        rd(8'h34, "R9 trim write");
        wr(8'h34, 32'h0000_0030);
        rd(8'h34, "R9 trim rewrite");

        repeat (2) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule